// File: doc/BRIEF.md
# Two-Source Arrival-Order Bus Arbiter

This block shares one 8-bit output bus between two character producers. Each producer presents a byte, a strobe and a hold length. The arbiter notices a request when a producer's byte changes from the value it held at the previous clock edge, or when its strobe is high. Each request is stored in a small queue in the order it arrived, and the queue is emptied one entry at a time onto the bus.

Every granted entry stays on the bus with the valid flag high for the number of cycles requested with it. A select output names the producer that owns the current bus value. When one entry's time runs out and another is waiting, the next one is granted in the same cycle, so the bus stays busy without a gap. If the queue is full, a new request is discarded, the entries already stored are kept, and a one-cycle drop flag is raised.

Top module: `dual_src_queue_arb`

## Requirements
- R1: While rst_n is low, and after it is released until the first grant, bus_valid, bus_sel, bus_data and ovf_drop are all 0 and the queue is empty.
- R2: At a rising clock edge, a source raises a request if its strobe is high or its data differs from the data sampled at the previous edge. The previous value is 0 right after reset. With the strobe low and the data unchanged, no request is raised.
- R3: Requests are granted in the order of the clock edges at which they arrived.
- R4: If both sources raise a request at the same edge, the source 1 request is queued and granted before the source 2 request.
- R5: bus_sel is 0 while a source 1 request is on the bus and 1 while a source 2 request is on the bus. bus_data carries the byte that was sampled with that request.
- R6: A granted request keeps bus_valid high for H cycles, where H is the hold input sampled with the request (4 bits; 0 is taken as 1). bus_data and bus_sel do not change during those cycles.
- R7: If the queue is not empty in the last cycle of a grant, the next entry appears on the next cycle with no idle cycle in between.
- R8: When nothing is granted, bus_valid is 0 and bus_data and bus_sel keep their last values.
- R9: The queue holds DEPTH entries (default 8). A request that finds the queue full is dropped without disturbing stored entries, and ovf_drop is high for the one cycle after that edge. When one slot is left and both sources request, the source 1 request takes the slot. An entry granted at an edge frees its slot for requests at that same edge.
- R10: A request sampled at edge k into an empty queue, with the bus idle, appears on the bus after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src1_data | input | 8 | Source 1 character |
| src1_stb | input | 1 | Source 1 forced request strobe |
| src1_hold | input | 4 | Source 1 hold length in cycles (0 means 1) |
| src2_data | input | 8 | Source 2 character |
| src2_stb | input | 1 | Source 2 forced request strobe |
| src2_hold | input | 4 | Source 2 hold length in cycles (0 means 1) |
| bus_data | output | 8 | Shared bus data |
| bus_valid | output | 1 | Bus carries a granted value |
| bus_sel | output | 1 | Owner of bus value: 0 source 1, 1 source 2 |
| ovf_drop | output | 1 | One-cycle pulse after a request was dropped on a full queue |

## Verification
A behavioural queue model in the bench predicts all outputs every cycle. It is driven through several patterns. Lone changes and strobes with the data held steady separate real change detection from level sensitivity. Staggered arrivals from alternating sources show whether the order is first-come or priority-based. Simultaneous arrivals expose the tie rule. Hold values of 0, 1 and 15 separate the minimum clamp and the counter end points. A burst that outruns the queue shows whether the arbiter drops new requests or overwrites stored ones, and whether source 1 wins the last free slot. A scripted check also times the first grant from an idle bus.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int DATA_W = 8;
  localparam int HOLD_W = 4;
  localparam int SRC_N  = 2;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              src;
    logic [HOLD_W-1:0] hold;
  } arb_entry_t;
endpackage

// File: rtl/arb_chg_det.sv
module arb_chg_det
  import arb_pkg::*;
#(
  parameter bit SRC_ID = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              stb,
  input  logic [HOLD_W-1:0] hold_len,
  output logic              req,
  output arb_entry_t        ent
);
  logic [DATA_W-1:0] prev_q;
  logic [DATA_W-1:0] prev_d;

  always_comb prev_d = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  always_comb begin
    req      = stb | (din != prev_q);
    ent.data = din;
    ent.src  = SRC_ID;
    ent.hold = (hold_len == '0) ? HOLD_W'(1) : hold_len;
  end

  // R6
  hold_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (ent.hold != '0));
endmodule

// File: rtl/arb_req_fifo.sv
module arb_req_fifo
  import arb_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] push_req,
  input  arb_entry_t       push_ent [SRC_N],
  input  logic             pop,
  output arb_entry_t       head,
  output logic             empty,
  output logic             ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  arb_entry_t       mem [DEPTH];
  logic [AW-1:0]    rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic [SRC_N-1:0] wr_en;
  logic [AW-1:0]    wr_idx [SRC_N];

  function automatic logic [AW-1:0] ptr_add(input logic [AW-1:0] p, input int k);
    int s;
    s = int'(p) + k;
    if (s >= DEPTH) s = s - DEPTH;
    return AW'(s);
  endfunction

  // next state: one pop, then pushes in source order while room remains
  always_comb begin
    int used;
    int taken;
    used  = int'(cnt_q) - int'(pop);
    taken = 0;
    ovf_d = 1'b0;
    for (int i = 0; i < SRC_N; i++) begin
      wr_en[i]  = 1'b0;
      wr_idx[i] = ptr_add(wr_q, taken);
      if (push_req[i]) begin
        if (used + taken < DEPTH) begin
          wr_en[i] = 1'b1;
          taken    = taken + 1;
        end else begin
          ovf_d = 1'b1;
        end
      end
    end
    wr_d  = ptr_add(wr_q, taken);
    rd_d  = pop ? ptr_add(rd_q, 1) : rd_q;
    cnt_d = CW'(used + taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SRC_N; i++) begin
      if (wr_en[i]) mem[wr_idx[i]] <= push_ent[i];
    end
  end

  always_comb begin
    head  = mem[rd_q];
    empty = (cnt_q == '0);
    ovf   = ovf_q;
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH) && !pop && |push_req) |=> ovf);
  // R3
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/arb_bus_drv.sv
module arb_bus_drv
  import arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              empty,
  input  arb_entry_t        head,
  output logic              pop,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_sel,
  output logic              bus_valid
);
  logic [HOLD_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              sel_q, sel_d;
  logic              valid_q, valid_d;
  logic              slot_end;

  always_comb begin
    slot_end = !valid_q || (cnt_q == HOLD_W'(1));
    pop      = slot_end && !empty;
    data_d   = data_q;
    sel_d    = sel_q;
    valid_d  = valid_q;
    cnt_d    = cnt_q;
    if (pop) begin
      data_d  = head.data;
      sel_d   = head.src;
      valid_d = 1'b1;
      cnt_d   = head.hold;
    end else if (valid_q && slot_end) begin
      valid_d = 1'b0;
      cnt_d   = '0;
    end else if (valid_q) begin
      cnt_d = cnt_q - HOLD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      data_q  <= '0;
      sel_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      data_q  <= data_d;
      sel_q   <= sel_d;
      valid_q <= valid_d;
    end
  end

  always_comb begin
    bus_data  = data_q;
    bus_sel   = sel_q;
    bus_valid = valid_q;
  end

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && cnt_q > HOLD_W'(1)) |=> (valid_q && $stable(data_q) && $stable(sel_q)));
  // R7
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && cnt_q == HOLD_W'(1) && !empty) |=> valid_q);
  // R8
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && empty) |=> (!valid_q && $stable(data_q) && $stable(sel_q)));
  // R6
  live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (cnt_q != '0));
endmodule

// File: rtl/dual_src_queue_arb.sv
module dual_src_queue_arb
  import arb_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src1_data,
  input  logic              src1_stb,
  input  logic [HOLD_W-1:0] src1_hold,
  input  logic [DATA_W-1:0] src2_data,
  input  logic              src2_stb,
  input  logic [HOLD_W-1:0] src2_hold,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_valid,
  output logic              bus_sel,
  output logic              ovf_drop
);
  logic [DATA_W-1:0] din_a  [SRC_N];
  logic              stb_a  [SRC_N];
  logic [HOLD_W-1:0] hold_a [SRC_N];
  arb_entry_t        ent_a  [SRC_N];
  logic [SRC_N-1:0]  req_v;
  arb_entry_t        head;
  logic              empty;
  logic              pop;

  always_comb begin
    din_a[0]  = src1_data;
    stb_a[0]  = src1_stb;
    hold_a[0] = src1_hold;
    din_a[1]  = src2_data;
    stb_a[1]  = src2_stb;
    hold_a[1] = src2_hold;
  end

  for (genvar g = 0; g < SRC_N; g++) begin : g_det
    arb_chg_det #(.SRC_ID(g[0])) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (din_a[g]),
      .stb      (stb_a[g]),
      .hold_len (hold_a[g]),
      .req      (req_v[g]),
      .ent      (ent_a[g])
    );
  end

  arb_req_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (req_v),
    .push_ent (ent_a),
    .pop      (pop),
    .head     (head),
    .empty    (empty),
    .ovf      (ovf_drop)
  );

  arb_bus_drv u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .empty     (empty),
    .head      (head),
    .pop       (pop),
    .bus_data  (bus_data),
    .bus_sel   (bus_sel),
    .bus_valid (bus_valid)
  );
endmodule

// File: tb/dual_src_queue_arb_tb.sv
module dual_src_queue_arb_tb;
  localparam int DEPTH = 8;

  logic       clk;
  logic       rst_n;
  logic [7:0] s1_data, s2_data;
  logic       s1_stb, s2_stb;
  logic [3:0] s1_hold, s2_hold;
  logic [7:0] bus_data;
  logic       bus_valid, bus_sel, ovf_drop;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  string phase = "R1";

  // behavioural reference
  int         mq[$];
  logic       m_valid, m_sel, m_ovf;
  logic [7:0] m_data, p1, p2;
  int         m_cnt;

  dual_src_queue_arb #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .src1_data(s1_data), .src1_stb(s1_stb), .src1_hold(s1_hold),
    .src2_data(s2_data), .src2_stb(s2_stb), .src2_hold(s2_hold),
    .bus_data(bus_data), .bus_valid(bus_valid), .bus_sel(bus_sel), .ovf_drop(ovf_drop)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int hclamp(input logic [3:0] h);
    return (h == 4'd0) ? 1 : int'(h);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_valid = 0; m_sel = 0; m_ovf = 0; m_data = 0; m_cnt = 0; p1 = 0; p2 = 0;
    end else begin
      bit drop;
      if ((!m_valid || m_cnt == 1) && mq.size() > 0) begin
        int e;
        e = mq.pop_front();
        m_data  = e[7:0];
        m_sel   = e[8];
        m_cnt   = e >> 9;
        m_valid = 1;
      end else if (m_valid && m_cnt == 1) begin
        m_valid = 0;
        m_cnt   = 0;
      end else if (m_valid) begin
        m_cnt--;
      end
      drop = 0;
      if (s1_stb || s1_data != p1) begin
        if (mq.size() < DEPTH) mq.push_back(int'(s1_data) | (0 << 8) | (hclamp(s1_hold) << 9));
        else drop = 1;
      end
      if (s2_stb || s2_data != p2) begin
        if (mq.size() < DEPTH) mq.push_back(int'(s2_data) | (1 << 8) | (hclamp(s2_hold) << 9));
        else drop = 1;
      end
      m_ovf = drop;
      p1 = s1_data;
      p2 = s2_data;
    end
  end

  always @(posedge clk) begin
    #2;
    chk(bus_valid == m_valid, phase, "bus_valid", bus_valid, m_valid);
    chk(bus_data == m_data, phase, "bus_data", bus_data, m_data);
    chk(bus_sel == m_sel, phase, "bus_sel", bus_sel, m_sel);
    chk(ovf_drop == m_ovf, phase, "ovf_drop", ovf_drop, m_ovf);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic put(input logic [7:0] d1, input logic t1, input logic [3:0] h1,
                     input logic [7:0] d2, input logic t2, input logic [3:0] h2);
    @(negedge clk);
    s1_data = d1; s1_stb = t1; s1_hold = h1;
    s2_data = d2; s2_stb = t2; s2_hold = h2;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      s1_stb = 0;
      s2_stb = 0;
    end
  endtask

  initial begin
    rst_n = 0;
    s1_data = 0; s2_data = 0; s1_stb = 0; s2_stb = 0; s1_hold = 1; s2_hold = 1;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(bus_valid == 0, "R1", "reset bus_valid", bus_valid, 0);
    chk(bus_data == 0, "R1", "reset bus_data", bus_data, 0);
    chk(bus_sel == 0, "R1", "reset bus_sel", bus_sel, 0);
    chk(ovf_drop == 0, "R1", "reset ovf_drop", ovf_drop, 0);
    rst_n = 1;
    idle(3);

    // R10 first-grant latency from idle
    phase = "R10";
    put(8'h41, 0, 4'd2, 8'h00, 0, 4'd1);
    @(posedge clk); #2;
    chk(bus_valid == 0, "R10", "valid one edge after request", bus_valid, 0);
    @(posedge clk); #2;
    chk(bus_valid == 1, "R10", "valid two edges after request", bus_valid, 1);
    chk(bus_data == 8'h41, "R5", "granted byte", bus_data, 8'h41);
    chk(bus_sel == 0, "R5", "granted source", bus_sel, 0);
    idle(6);

    // R2 unchanged data makes no request, strobe does
    phase = "R2";
    idle(4);
    chk(bus_valid == 0, "R2", "steady data idle", bus_valid, 0);
    put(8'h41, 1, 4'd1, 8'h00, 0, 4'd1);
    idle(4);
    put(8'h41, 0, 4'd1, 8'h00, 1, 4'd3);
    idle(6);

    // R3 staggered arrivals
    phase = "R3";
    put(8'h41, 0, 4'd3, 8'h10, 0, 4'd2);
    put(8'h52, 0, 4'd2, 8'h10, 0, 4'd2);
    put(8'h52, 0, 4'd2, 8'h11, 0, 4'd1);
    idle(15);

    // R4 simultaneous arrivals
    phase = "R4";
    put(8'h60, 0, 4'd2, 8'h70, 0, 4'd2);
    put(8'h61, 0, 4'd1, 8'h71, 0, 4'd1);
    idle(12);

    // R6 hold lengths including 0 and 15
    phase = "R6";
    put(8'h80, 0, 4'd0, 8'h70, 0, 4'd1);
    put(8'h80, 0, 4'd0, 8'h90, 0, 4'd15);
    put(8'h81, 0, 4'd1, 8'h90, 0, 4'd15);
    idle(25);

    // R7 back to back, R8 idle afterwards
    phase = "R7";
    for (int i = 0; i < 5; i++) put(8'(8'hA0 + i), 0, 4'(i + 1), 8'(8'hB0 + i), 0, 4'(5 - i));
    idle(40);
    phase = "R8";
    idle(5);

    // R9 burst past the queue depth
    phase = "R9";
    put(8'hC0, 0, 4'd15, 8'hD0, 0, 4'd15);
    for (int i = 1; i < 8; i++) put(8'(8'hC0 + i), 0, 4'd2, 8'(8'hD0 + i), 0, 4'd3);
    idle(3);
    put(8'hCF, 0, 4'd1, 8'hDF, 0, 4'd1);
    idle(160);

    // R5 mixed traffic
    phase = "R5";
    for (int i = 0; i < 60; i++) begin
      put(8'((i * 37 + 5) & 255), (i % 7) == 0, 4'(i % 5),
          (i % 3 == 0) ? 8'((i * 11) & 255) : s2_data, (i % 4) == 1, 4'(i % 3));
    end
    idle(200);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule